// File: doc/BRIEF.md
# Daisy-chain auto-addressing controller

This block is the slave-side controller that gives a node its bus address from its place in a chain of dual-segment nodes. Each node sits between an upstream segment, which leads toward the master, and a downstream segment, which leads to later nodes. A protocol engine on the upstream segment hands the block decoded frame events. It gives a header strobe with the frame identifier, then the data bytes of that frame as a valid/ready stream. The block drives the node address, an addressed flag, and the enable that lets the repeater connect the downstream segment.

After reset the node is unaddressed and the downstream segment is cut off. Only the nearest unaddressed node can therefore hear the master. A node takes its address from the first assignment command it hears. It then raises a one-cycle acknowledge so the engine can answer, and it connects the downstream segment. From then on it ignores further assignments, so the master reaches the next node in the chain. A clear command returns the node to the unaddressed, isolated state.

Commands travel in frames with the identifier `CMD_ID`. The first data byte is an opcode and the second data byte is its argument. The byte stream uses a valid/ready handshake, and a byte counts as accepted on a rising edge where both `rx_valid` and `rx_ready` are high. The block pulls `rx_ready` low for exactly one cycle, the commit cycle after a command's last byte. A byte offered in that cycle is held by the engine and accepted on the next cycle.

Top module: `chain_autoaddr`

## Requirements
- R1: After reset, `addressed`, `fwd_en` and `assign_ack` are 0, `node_addr` is 0 and `rx_ready` is 1.
- R2: While the node is unaddressed, a frame with header ID `CMD_ID`, byte 0 = `OP_ASSIGN` (default 8'h01) and byte 1 = A updates the outputs on the second rising edge after byte 1 is accepted: `node_addr` becomes A and `addressed` becomes 1.
- R3: `fwd_en` is 1 exactly when `addressed` is 1. This means downstream forwarding is enabled only once an address is held.
- R4: `assign_ack` is high for exactly one cycle. It rises in the same cycle that `addressed` rises, and it is never raised otherwise.
- R5: An assignment command received while the node is addressed changes nothing: `node_addr` keeps its value and no acknowledge appears.
- R6: A command frame with byte 0 = `OP_CLEAR` (default 8'h02) returns the node to the unaddressed state, with `addressed`=0, `fwd_en`=0 and `node_addr`=0. It gives no acknowledge.
- R7: Data bytes of a frame whose header ID differs from `CMD_ID` are ignored.
- R8: Data bytes not preceded by a `CMD_ID` header are ignored, and so are bytes after the second byte of a command frame. A new header that arrives mid-frame discards the partial command.
- R9: `rx_ready` is 0 only in the cycle that follows acceptance of a command's last byte, and it is 1 again in the cycle after that.
- R10: A command frame whose opcode is neither `OP_ASSIGN` nor `OP_CLEAR` leaves the node state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | One-cycle strobe: a header was decoded on the upstream segment |
| hdr_id | input | ID_W | Frame identifier carried by the header |
| rx_valid | input | 1 | A data byte is offered |
| rx_data | input | DATA_W | Offered data byte |
| rx_ready | output | 1 | The block can accept a byte this cycle |
| node_addr | output | ADDR_W | Assigned node address, 0 while unaddressed |
| addressed | output | 1 | The node holds an address |
| fwd_en | output | 1 | Enable for the repeater toward the downstream segment |
| assign_ack | output | 1 | One-cycle strobe when an address has just been taken |

## Verification
Some properties are checked on every cycle. These are the coupling of `fwd_en` to `addressed`, the single-cycle acknowledge that coincides only with the rise of `addressed`, a held address that stays frozen while addressed, a zero address while unaddressed, and the one-cycle `rx_ready` gap. Other behaviour can only be shown by the bench's frame sequences. This covers that the right frame produces the right address, and that foreign IDs, stray bytes, unknown opcodes, aborted frames and repeated assignments produce nothing. The bench scoreboard also confirms that each acknowledge matches an expected assignment and carries its address.

// File: rtl/autoaddr_pkg.sv
package autoaddr_pkg;
  // Number of data bytes that make up a command: opcode, then argument.
  localparam int CMD_BYTES = 2;
  localparam int SLOT_W    = (CMD_BYTES > 1) ? $clog2(CMD_BYTES) : 1;

  typedef enum logic {
    ST_UNADDR = 1'b0,
    ST_ADDRD  = 1'b1
  } addr_state_e;
endpackage

// File: rtl/autoaddr_frame_track.sv
module autoaddr_frame_track
  import autoaddr_pkg::*;
#(
  parameter int             ID_W   = 6,
  parameter logic [ID_W-1:0] CMD_ID = 6'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [ID_W-1:0]   hdr_id,
  input  logic              rx_valid,
  input  logic              rx_ready,
  output logic              take,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CMD_BYTES - 1);

  logic              armed_q;
  logic [SLOT_W-1:0] slot_q;

  // A header in the same cycle as a byte wins; the byte is dropped.
  assign take = armed_q && rx_valid && rx_ready && !hdr_valid;
  assign slot = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      slot_q  <= '0;
    end else if (hdr_valid) begin
      armed_q <= (hdr_id == CMD_ID);
      slot_q  <= '0;
    end else if (take) begin
      if (slot_q == LAST_SLOT) begin
        armed_q <= 1'b0;
        slot_q  <= '0;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/autoaddr_cmd_latch.sv
module autoaddr_cmd_latch
  import autoaddr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             take,
  input  logic [SLOT_W-1:0]                slot,
  input  logic [DATA_W-1:0]                rx_data,
  output logic [CMD_BYTES-1:0][DATA_W-1:0] cmd_bytes,
  output logic                             fire
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CMD_BYTES - 1);

  logic [CMD_BYTES-1:0][DATA_W-1:0] bytes_q;

  for (genvar i = 0; i < CMD_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bytes_q[i] <= '0;
      end else if (take && slot == SLOT_W'(i)) begin
        bytes_q[i] <= rx_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire <= 1'b0;
    else        fire <= take && (slot == LAST_SLOT);
  end

  assign cmd_bytes = bytes_q;
endmodule

// File: rtl/autoaddr_fsm.sv
module autoaddr_fsm
  import autoaddr_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter int               ADDR_W    = 8,
  parameter logic [DATA_W-1:0] OP_ASSIGN = 8'h01,
  parameter logic [DATA_W-1:0] OP_CLEAR  = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DATA_W-1:0] opcode,
  input  logic [ADDR_W-1:0] arg,
  output logic [ADDR_W-1:0] node_addr,
  output logic              addressed,
  output logic              fwd_en,
  output logic              assign_ack
);
  addr_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              fwd_q, fwd_d;
  logic              ack_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    fwd_d   = fwd_q;
    ack_d   = 1'b0;
    if (fire) begin
      if (opcode == OP_ASSIGN && state_q == ST_UNADDR) begin
        state_d = ST_ADDRD;
        addr_d  = arg;
        fwd_d   = 1'b1;
        ack_d   = 1'b1;
      end else if (opcode == OP_CLEAR) begin
        state_d = ST_UNADDR;
        addr_d  = '0;
        fwd_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_UNADDR;
      addr_q     <= '0;
      fwd_q      <= 1'b0;
      assign_ack <= 1'b0;
    end else begin
      state_q    <= state_d;
      addr_q     <= addr_d;
      fwd_q      <= fwd_d;
      assign_ack <= ack_d;
    end
  end

  assign node_addr = addr_q;
  assign addressed = (state_q == ST_ADDRD);
  assign fwd_en    = fwd_q;
endmodule

// File: rtl/chain_autoaddr.sv
module chain_autoaddr
  import autoaddr_pkg::*;
#(
  parameter int               ID_W      = 6,
  parameter int               DATA_W    = 8,
  parameter int               ADDR_W    = 8,
  parameter logic [ID_W-1:0]  CMD_ID    = 6'h3C,
  parameter logic [DATA_W-1:0] OP_ASSIGN = 8'h01,
  parameter logic [DATA_W-1:0] OP_CLEAR  = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [ID_W-1:0]   hdr_id,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic [ADDR_W-1:0] node_addr,
  output logic              addressed,
  output logic              fwd_en,
  output logic              assign_ack
);
  logic                             take;
  logic [SLOT_W-1:0]                slot;
  logic [CMD_BYTES-1:0][DATA_W-1:0] cmd_bytes;
  logic                             fire;

  // One-cycle back-pressure while a completed command is committed.
  assign rx_ready = !fire;

  autoaddr_frame_track #(.ID_W(ID_W), .CMD_ID(CMD_ID)) u_track (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_id(hdr_id),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .take(take), .slot(slot)
  );

  autoaddr_cmd_latch #(.DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .take(take), .slot(slot), .rx_data(rx_data),
    .cmd_bytes(cmd_bytes), .fire(fire)
  );

  autoaddr_fsm #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OP_ASSIGN(OP_ASSIGN), .OP_CLEAR(OP_CLEAR)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .fire(fire), .opcode(cmd_bytes[0]),
    .arg(cmd_bytes[1][ADDR_W-1:0]), .node_addr(node_addr),
    .addressed(addressed), .fwd_en(fwd_en), .assign_ack(assign_ack)
  );
endmodule

// File: rtl/chain_autoaddr_chk.sv
module chain_autoaddr_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_ready,
  input logic [ADDR_W-1:0] node_addr,
  input logic              addressed,
  input logic              fwd_en,
  input logic              assign_ack
);
  assert_fwd_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_en == addressed);

  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    assign_ack |=> !assign_ack);

  assert_ack_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    assign_ack |-> (addressed && !$past(addressed)));

  assert_addr_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addressed && $past(addressed)) |-> $stable(node_addr));

  assert_unaddr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !addressed |-> (node_addr == '0));

  assert_ready_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |=> rx_ready);
endmodule

bind chain_autoaddr chain_autoaddr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .node_addr(node_addr),
  .addressed(addressed), .fwd_en(fwd_en), .assign_ack(assign_ack)
);

// File: tb/chain_autoaddr_bench.sv
module chain_autoaddr_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] CMD_ID = 6'h3C;
  localparam logic [7:0] OP_ASSIGN = 8'h01;
  localparam logic [7:0] OP_CLEAR  = 8'h02;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hdr_valid = 1'b0;
  logic [5:0] hdr_id = '0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready;
  logic [7:0] node_addr;
  logic       addressed, fwd_en, assign_ack;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  logic prev_ack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_autoaddr u_chain_autoaddr (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_id(hdr_id),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .node_addr(node_addr), .addressed(addressed), .fwd_en(fwd_en),
    .assign_ack(assign_ack)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: every acknowledge must match a queued assignment (R4, R2).
  always @(negedge clk) begin
    if (rst_n) begin
      if (assign_ack) begin
        check(!prev_ack, "R4 ack longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected acknowledge", 1, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(node_addr == e, "R2 address at acknowledge", node_addr, e);
          check(addressed, "R4 addressed with acknowledge", addressed, 1);
        end
      end
      prev_ack = assign_ack;
    end
  end

  task automatic send_hdr(input logic [5:0] id);
    @(negedge clk);
    hdr_valid = 1'b1;
    hdr_id = id;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  // Offers one byte; returns at the negedge after it was accepted.
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // Full command frame; returns once the outputs reflect the commit.
  task automatic send_cmd(input logic [5:0] id, input logic [7:0] op,
                          input logic [7:0] arg, input bit is_cmd);
    send_hdr(id);
    send_byte(op);
    send_byte(arg);
    if (is_cmd) check(rx_ready == 1'b0, "R9 ready low in commit cycle", rx_ready, 0);
    @(negedge clk);
    check(rx_ready == 1'b1, "R9 ready back high", rx_ready, 1);
  endtask

  task automatic expect_state(input string tag, input bit a, input logic [7:0] addr);
    check(addressed == a, {tag, " addressed"}, addressed, a);
    check(fwd_en == a, {"R3 fwd_en ", tag}, fwd_en, a);
    check(node_addr == addr, {tag, " node_addr"}, node_addr, addr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(addressed == 1'b0, "R1 addressed after reset", addressed, 0);
    check(fwd_en == 1'b0, "R1 fwd_en after reset", fwd_en, 0);
    check(node_addr == 8'h00, "R1 node_addr after reset", node_addr, 0);
    check(assign_ack == 1'b0, "R1 ack after reset", assign_ack, 0);
    check(rx_ready == 1'b1, "R1 ready after reset", rx_ready, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: stray bytes with no header
    send_byte(OP_ASSIGN);
    send_byte(8'h11);
    repeat (2) @(negedge clk);
    expect_state("R8 no header", 1'b0, 8'h00);

    // R7: frame with a foreign ID
    send_cmd(6'h10, OP_ASSIGN, 8'h12, 1'b0);
    expect_state("R7 foreign id", 1'b0, 8'h00);

    // R10: unknown opcode
    send_cmd(CMD_ID, 8'h07, 8'h13, 1'b1);
    expect_state("R10 unknown opcode", 1'b0, 8'h00);

    // R2, R3, R4: assignment
    exp_q.push_back(8'h15);
    send_cmd(CMD_ID, OP_ASSIGN, 8'h15, 1'b1);
    expect_state("R2 assign", 1'b1, 8'h15);
    @(negedge clk);
    check(assign_ack == 1'b0, "R4 ack dropped", assign_ack, 0);

    // R5: second assignment ignored
    send_cmd(CMD_ID, OP_ASSIGN, 8'h2A, 1'b1);
    expect_state("R5 repeat assign", 1'b1, 8'h15);

    // R6: clear
    send_cmd(CMD_ID, OP_CLEAR, 8'h00, 1'b1);
    expect_state("R6 clear", 1'b0, 8'h00);

    // R8: header mid-frame discards the partial command
    send_hdr(CMD_ID);
    send_byte(OP_ASSIGN);
    send_hdr(6'h21);
    send_byte(8'h2B);
    repeat (2) @(negedge clk);
    expect_state("R8 aborted frame", 1'b0, 8'h00);

    // R2 and R8: reassignment, extra trailing byte ignored
    exp_q.push_back(8'h2B);
    send_cmd(CMD_ID, OP_ASSIGN, 8'h2B, 1'b1);
    send_byte(8'h3F);
    repeat (2) @(negedge clk);
    expect_state("R8 trailing byte", 1'b1, 8'h2B);

    // R6: clear from addressed, then assign a new address
    send_cmd(CMD_ID, OP_CLEAR, 8'h55, 1'b1);
    expect_state("R6 clear again", 1'b0, 8'h00);
    exp_q.push_back(8'h01);
    send_cmd(CMD_ID, OP_ASSIGN, 8'h01, 1'b1);
    expect_state("R2 assign after clear", 1'b1, 8'h01);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4 missing acknowledges", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule